// File: doc/BRIEF.md
# Background Bang-Bang Calibration Controller

This block closes a slow digital loop around an external comparator. It drives the input code of a low-speed reference DAC, and that DAC sets a compensation voltage. The comparator reports whether the compensation is too small. On each decision the block moves the code one step towards balance. The loop dithers around the point where the two sensed quantities match. The block treats that dithering as convergence and keeps the resulting code on its output until the next run.

Calibration is meant to run now and then in the background, because the drift it follows is slow. A run starts with a single-cycle request while the block is idle. A run begins with a blanking phase of fixed length, during which the comparator cancels its own offset and its output is not used. After that the block makes decisions, each one taken after a fixed settling delay. A run ends in one of two ways: the loop locks, or a step budget runs out and the block raises an error flag.

Top module: `bbcal_ctrl`

## Requirements
- R1: After reset, `dac_code` equals RESET_CODE (default 32) and `busy`, `locked` and `cal_err` are 0.
- R2: When `cal_req` is high at a clock edge while the block is idle, `busy` is 1 after that edge, and `locked` and `cal_err` are cleared at the same edge.
- R3: During the first OFS_CYC cycles of a run (the offset-cancel phase), `cmp_up` has no effect on the code.
- R4: Decision k of a run (k = 1, 2, ...) samples `cmp_up` at the edge OFS_CYC + SETTLE_CYC*k cycles after the accepting edge. Any new code appears right after that edge.
- R5: At a decision where no lock occurs, `cmp_up` = 1 raises `dac_code` by one and `cmp_up` = 0 lowers it by one.
- R6: The code saturates. An up step at 2^CODE_W-1 leaves it there, and a down step at 0 leaves it at 0. Such a decision still counts as a step and still records its direction.
- R7: A decision is a reversal if its direction differs from the previous decision of the same run. The first decision of a run is never a reversal. Any non-reversing decision resets the streak. At the LOCK_REVS-th consecutive reversal the code is not stepped, the run ends, `locked` goes to 1 and `busy` goes to 0.
- R8: If MAX_STEPS decisions have been stepped without lock, the run ends after the last step with `cal_err` = 1, `locked` = 0 and `busy` = 0.
- R9: While idle, `dac_code` holds its value whatever `cmp_up` does.
- R10: A `cal_req` that arrives while `busy` is 1 is dropped. It neither restarts nor extends the run, and the block does not start another run afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req | input | 1 | Start a calibration run (taken only when idle) |
| cmp_up | input | 1 | Comparator decision: 1 = raise code, 0 = lower code |
| dac_code | output | CODE_W | Code for the reference DAC |
| busy | output | 1 | A run is in progress |
| locked | output | 1 | Last run converged |
| cal_err | output | 1 | Last run ran out of steps |

## Verification
The bench drives the code into both rails and checks that it pins at full scale and at zero rather than wrapping; a wrapping counter would finish those runs far from the expected code. It feeds a pattern of two ups and two downs that reverses often but never several times in a row. A design that counted total reversals instead of a consecutive streak would lock on it, where the correct design reaches the step limit. It also holds the comparator at the wrong value through the offset phase and the first settling cycle. A design that sampled early would step the wrong way. Finally it pulses the request mid-run and checks that no second run follows.

// File: rtl/bbcal_pkg.sv
package bbcal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OFFSET = 2'd1,
        ST_SETTLE = 2'd2
    } cal_state_t;

endpackage

// File: rtl/bbcal_step.sv
// Saturating one-LSB step of the DAC code.
module bbcal_step #(
    parameter int W = 6
) (
    input  logic [W-1:0] code_i,
    input  logic         up_i,
    output logic [W-1:0] code_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_comb begin
        if (up_i) begin
            code_o = (code_i == TOP) ? code_i : code_i + W'(1);
        end else begin
            code_o = (code_i == '0) ? code_i : code_i - W'(1);
        end
    end
endmodule

// File: rtl/bbcal_revtrack.sv
// Tracks a streak of consecutive direction reversals.
module bbcal_revtrack #(
    parameter int REV_W     = 2,
    parameter int LOCK_REVS = 3
) (
    input  logic             have_last_i,
    input  logic             last_up_i,
    input  logic             up_i,
    input  logic [REV_W-1:0] revs_i,
    output logic [REV_W-1:0] revs_o,
    output logic             lock_o
);
    logic flip;

    always_comb begin
        flip   = have_last_i && (last_up_i != up_i);
        revs_o = flip ? revs_i + REV_W'(1) : '0;
        lock_o = flip && (revs_i == REV_W'(LOCK_REVS - 1));
    end
endmodule

// File: rtl/bbcal_ctrl.sv
module bbcal_ctrl
    import bbcal_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter int RESET_CODE = 32,
    parameter int OFS_CYC    = 3,
    parameter int SETTLE_CYC = 2,
    parameter int LOCK_REVS  = 3,
    parameter int MAX_STEPS  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_req,
    input  logic              cmp_up,
    output logic [CODE_W-1:0] dac_code,
    output logic              busy,
    output logic              locked,
    output logic              cal_err
);
    localparam int TMR_MAX = (OFS_CYC > SETTLE_CYC) ? OFS_CYC : SETTLE_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int STEP_W  = $clog2(MAX_STEPS + 1);
    localparam int REV_W   = $clog2(LOCK_REVS + 1);

    localparam logic [TMR_W-1:0]  OFS_LOAD  = TMR_W'(OFS_CYC - 1);
    localparam logic [TMR_W-1:0]  SET_LOAD  = TMR_W'(SETTLE_CYC - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(MAX_STEPS - 1);

    typedef struct packed {
        cal_state_t        st;
        logic [CODE_W-1:0] code;
        logic [TMR_W-1:0]  tmr;
        logic [STEP_W-1:0] steps;
        logic [REV_W-1:0]  revs;
        logic              last_up;
        logic              have_last;
        logic              locked;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    logic [CODE_W-1:0] stepped_code;
    logic [REV_W-1:0]  revs_nxt;
    logic              lock_hit;

    bbcal_step #(.W(CODE_W)) u_step (
        .code_i (r_q.code),
        .up_i   (cmp_up),
        .code_o (stepped_code)
    );

    bbcal_revtrack #(.REV_W(REV_W), .LOCK_REVS(LOCK_REVS)) u_rev (
        .have_last_i (r_q.have_last),
        .last_up_i   (r_q.last_up),
        .up_i        (cmp_up),
        .revs_i      (r_q.revs),
        .revs_o      (revs_nxt),
        .lock_o      (lock_hit)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cal_req) begin
                    r_d.st        = ST_OFFSET;
                    r_d.tmr       = OFS_LOAD;
                    r_d.steps     = '0;
                    r_d.revs      = '0;
                    r_d.have_last = 1'b0;
                    r_d.locked    = 1'b0;
                    r_d.err       = 1'b0;
                end
            end
            ST_OFFSET: begin
                if (r_q.tmr == '0) begin
                    r_d.st  = ST_SETTLE;
                    r_d.tmr = SET_LOAD;
                end else begin
                    r_d.tmr = r_q.tmr - TMR_W'(1);
                end
            end
            ST_SETTLE: begin
                if (r_q.tmr != '0) begin
                    r_d.tmr = r_q.tmr - TMR_W'(1);
                end else if (lock_hit) begin
                    r_d.st     = ST_IDLE;
                    r_d.locked = 1'b1;
                end else begin
                    r_d.code      = stepped_code;
                    r_d.last_up   = cmp_up;
                    r_d.have_last = 1'b1;
                    r_d.revs      = revs_nxt;
                    r_d.steps     = r_q.steps + STEP_W'(1);
                    r_d.tmr       = SET_LOAD;
                    if (r_q.steps == STEP_LAST) begin
                        r_d.st  = ST_IDLE;
                        r_d.err = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= ST_IDLE;
            r_q.code      <= CODE_W'(RESET_CODE);
        end else begin
            r_q <= r_d;
        end
    end

    assign dac_code = r_q.code;
    assign busy     = (r_q.st != ST_IDLE);
    assign locked   = r_q.locked;
    assign cal_err  = r_q.err;

endmodule

// File: rtl/bbcal_chk.sv
module bbcal_chk #(
    parameter int CODE_W     = 6,
    parameter int OFS_CYC    = 3,
    parameter int SETTLE_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_req,
    input logic              busy,
    input logic              locked,
    input logic              cal_err,
    input logic [CODE_W-1:0] dac_code
);
    localparam logic [CODE_W-1:0] TOP  = {CODE_W{1'b1}};
    localparam int                HOLD = OFS_CYC + SETTLE_CYC - 1;

    logic [15:0] run_cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cyc <= '0;
        end else if (!busy) begin
            run_cyc <= '0;
        end else if (run_cyc != 16'hFFFF) begin
            run_cyc <= run_cyc + 16'd1;
        end
    end

    // R2: a run only begins after a request
    p_start_by_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cal_req));

    // R2: flags are clear while a run is active
    p_flags_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!locked && !cal_err));

    // R3: code frozen through offset phase and first settling window
    p_offset_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (run_cyc < 16'(HOLD))) |-> $stable(dac_code));

    // R5: code moves by at most one LSB per edge
    p_one_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(dac_code) ||
         (dac_code == CODE_W'($past(dac_code) + CODE_W'(1))) ||
         (dac_code == CODE_W'($past(dac_code) - CODE_W'(1)))));

    // R6: no wrap at the rails
    p_no_wrap_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dac_code) == TOP) |-> (dac_code != '0));
    p_no_wrap_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dac_code) == '0) |-> (dac_code != TOP));

    // R7/R8: outcomes are exclusive
    p_outcome_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && cal_err));

    // R9: idle code holds
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> $stable(dac_code));

endmodule

bind bbcal_ctrl bbcal_chk #(
    .CODE_W     (CODE_W),
    .OFS_CYC    (OFS_CYC),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_req  (cal_req),
    .busy     (busy),
    .locked   (locked),
    .cal_err  (cal_err),
    .dac_code (dac_code)
);

// File: tb/sim_bbcal_ctrl.sv
`timescale 1ns/1ps
module sim_bbcal_ctrl;
    localparam int CODE_W = 6;
    localparam int OFS    = 3;
    localparam int SET    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cal_req = 1'b0;
    logic              cmp_up = 1'b0;
    logic [CODE_W-1:0] dac_code;
    logic              busy, locked, cal_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bbcal_ctrl #(
        .CODE_W(CODE_W), .RESET_CODE(32), .OFS_CYC(OFS),
        .SETTLE_CYC(SET), .LOCK_REVS(3), .MAX_STEPS(40)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .cmp_up(cmp_up),
        .dac_code(dac_code), .busy(busy), .locked(locked), .cal_err(cal_err)
    );

    typedef struct packed {
        logic [15:0] pat;
        logic [5:0]  code;
        logic        lk;
        logic        er;
    } vec_t;

    // decision k uses pat[(k-1) % 16]; runs chain from code 32
    localparam vec_t VECS [8] = '{
        '{16'h5555, 6'd33, 1'b1, 1'b0},  // R7 alternate from 32
        '{16'h0017, 6'd36, 1'b1, 1'b0},  // R5 R7 climb then dither
        '{16'hFFFF, 6'd63, 1'b0, 1'b1},  // R6 R8 pin at top
        '{16'h0000, 6'd23, 1'b0, 1'b1},  // R8 forty downs
        '{16'h0000, 6'd0,  1'b0, 1'b1},  // R6 pin at zero
        '{16'hAAAA, 6'd0,  1'b1, 1'b0},  // R6 R7 lock at bottom rail
        '{16'h3333, 6'd0,  1'b0, 1'b1},  // R7 R8 non-consecutive reversals
        '{16'h5555, 6'd1,  1'b1, 1'b0}   // R7 relock
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_pat(input logic [15:0] pat);
        @(negedge clk);
        cal_req = 1'b1;
        cmp_up  = pat[0];
        @(posedge clk);
        @(negedge clk);
        cal_req = 1'b0;
        for (int k = 0; k < 200; k++) begin
            cmp_up = pat[k % 16];
            repeat ((k == 0) ? (OFS + SET) : SET) @(posedge clk);
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 code", dac_code, 32);
        chk("R1 busy", busy, 0);
        chk("R1 locked", locked, 0);
        chk("R1 err", cal_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 8; v++) begin
            run_pat(VECS[v].pat);
            chk($sformatf("R5 R6 R7 R8 vec%0d code", v), dac_code, VECS[v].code);
            chk($sformatf("R7 vec%0d locked", v), locked, VECS[v].lk);
            chk($sformatf("R8 vec%0d err", v), cal_err, VECS[v].er);
            chk($sformatf("R7 vec%0d busy", v), busy, 0);
        end

        // Directed: offset/settle sampling point, request during run
        @(negedge clk);
        cal_req = 1'b1;
        cmp_up  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cal_req = 1'b0;
        chk("R2 busy after req", busy, 1);
        chk("R2 locked cleared", locked, 0);
        repeat (OFS + SET - 1) @(posedge clk);   // through e4
        @(negedge clk);
        chk("R3 R4 code before first decision", dac_code, 1);
        cmp_up = 1'b1;
        @(posedge clk);                          // e5 decision 1: up
        @(negedge clk);
        chk("R4 R5 first decision up", dac_code, 2);
        cal_req = 1'b1;                          // R10: ignored
        cmp_up  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cal_req = 1'b0;
        @(posedge clk);                          // e7 decision 2: down
        @(negedge clk);
        chk("R5 second decision down", dac_code, 1);
        chk("R10 still busy", busy, 1);
        cmp_up = 1'b1;
        repeat (SET) @(posedge clk);             // e9 decision 3: up
        @(negedge clk);
        chk("R5 third decision up", dac_code, 2);
        cmp_up = 1'b0;
        repeat (SET) @(posedge clk);             // e11 decision 4: lock
        @(negedge clk);
        chk("R7 lock code held", dac_code, 2);
        chk("R7 locked", locked, 1);
        chk("R7 busy low", busy, 0);

        for (int i = 0; i < 8; i++) begin
            cmp_up = i[0];
            @(negedge clk);
            chk("R10 no late restart", busy, 0);
            chk("R9 idle code hold", dac_code, 2);
        end
        chk("R9 locked kept", locked, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule